// File: doc/BRIEF.md
# Elastic Jitter Attenuation Bit Buffer

This block is an elastic single-bit FIFO. It smooths the timing of a serial bit stream and can be placed in either the receive data path or the transmit data path of a line interface. The whole block runs on one master clock. Incoming bits arrive as write strobes paired with a data bit, and their spacing may be jittered. Outgoing bits leave on read strobes from a numerically controlled rate generator. That generator tracks the buffer's fill level, so over time the output rate settles to the average input rate while short-term phase wander is absorbed by the buffer.

A 2-bit mode input selects the setting:
- `00`: the block is off, and data and strobe pass straight through in the same cycle.
- `01`: broad tracking bandwidth with 64 bits of storage, receive side.
- `10`: narrow tracking bandwidth with 128 bits, receive side.
- `11`: narrow tracking bandwidth with 128 bits, transmit side.

A separate input shortens the store to 32 bits in any enabled mode. After reset or any change of depth, the read position is set half a depth behind the write position, so a bit leaves half a depth of reads after it entered. When the buffer is written while full, the block raises a sticky overflow flag. When it is read while empty, it raises a sticky underflow flag. In both cases the read position slips back to the half-depth point. An optional limit mode gives the rate generator an extra push when the fill comes close to either edge.

Top module: `jitter_buffer`

## Requirements
- R1: With `mode` = 00 the block is bypassed: `out_stb` equals `in_stb` and `out_bit` equals `in_bit` in the same cycle.
- R2: Depth is 64 for `mode` = 01 and 128 for `mode` = 10 or 11, or 32 whenever `depth_min` = 1 with a nonzero mode. Right after reset `fill_level` equals half the depth and both flags are 0.
- R3: When writes keep pace with reads, the bit read at position k (counting from 0 after reset) is the bit written at position k − depth/2. The first depth/2 reads after reset return 0.
- R4: `tx_side` is 1 only for `mode` = 11.
- R5: A write strobe that arrives while fill equals depth, with no read in the same cycle, is dropped. It sets `ovf_flag`, and `fill_level` returns to depth/2 at the same edge.
- R6: A read tick that arrives while fill is 0 produces no `out_stb`. It sets `unf_flag`, and `fill_level` returns to depth/2 at the same edge.
- R7: Both flags stay set until `flag_clr` is pulsed. `flag_clr` clears them at the next edge, and a new event in that same cycle wins over the clear.
- R8: The read rate comes from a 16-bit phase accumulator advanced each cycle by 8192 + (fill − depth/2)·G + L. G is 8 for broad bandwidth and 1 for narrow. A carry out of the accumulator causes a read, and `out_stb` rises at that edge. With no writes, the first `out_stb` after reset appears at the 8th clock edge and the second one 9 edges later.
- R9: With `limit_en` = 1, L is +2048 when fill is within M of depth and −2048 when fill ≤ M. M is 2, 3 or 4 for depth 32, 64 or 128. Otherwise L is 0. Limit mode therefore delays both overflow and underflow.
- R10: In enabled modes `out_stb` is never high on two consecutive cycles.
- R11: A change of depth or of the enabled state re-centres the buffer: `fill_level` becomes the new depth/2 at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Placement, bandwidth and depth select; 00 bypasses the block |
| depth_min | input | 1 | Forces a 32-bit store in enabled modes |
| limit_en | input | 1 | Enables the near-edge rate correction |
| flag_clr | input | 1 | Clears both sticky flags |
| in_stb | input | 1 | Write strobe, one per incoming bit |
| in_bit | input | 1 | Incoming data bit |
| out_stb | output | 1 | Read strobe, one per outgoing bit |
| out_bit | output | 1 | Outgoing data bit, valid while `out_stb` is high |
| fill_level | output | 8 | Number of bits currently held |
| tx_side | output | 1 | High when the buffer belongs in the transmit path |
| ovf_flag | output | 1 | Sticky overflow indication |
| unf_flag | output | 1 | Sticky underflow indication |

## Verification
The bench uses the default parameters: a 16-bit accumulator, a nominal step of 8192 and a limit step of 2048. These give a nominal read every 8 cycles, so the first and second read instants after reset can be predicted to the exact edge. Fill drifts slowly enough that the exact-edge overflow and underflow counts and the half-depth latency are reached within a few hundred cycles for all three depths. Limit mode is checked by comparing the time to overflow, and the time to underflow, with the correction on and with it off.

// File: rtl/jab_pkg.sv
package jab_pkg;

    localparam int MAX_DEPTH = 128;
    localparam int PTR_W     = $clog2(MAX_DEPTH);
    localparam int CNT_W     = PTR_W + 1;

    typedef enum logic [1:0] {
        JA_OFF       = 2'b00,
        JA_RX_BROAD  = 2'b01,
        JA_RX_NARROW = 2'b10,
        JA_TX_NARROW = 2'b11
    } ja_mode_e;

    typedef struct packed {
        logic             active;
        logic             tx_side;
        logic             broad;
        logic [CNT_W-1:0] depth;
        logic [CNT_W-1:0] half;
        logic [CNT_W-1:0] margin;
    } ja_cfg_t;

    function automatic ja_cfg_t ja_decode(input logic [1:0] mode, input logic short_d);
        ja_cfg_t c;
        c.active  = (ja_mode_e'(mode) != JA_OFF);
        c.tx_side = (ja_mode_e'(mode) == JA_TX_NARROW);
        c.broad   = (ja_mode_e'(mode) == JA_RX_BROAD);
        if (short_d)
            c.depth = CNT_W'(32);
        else if (ja_mode_e'(mode) == JA_RX_BROAD)
            c.depth = CNT_W'(64);
        else
            c.depth = CNT_W'(128);
        c.half   = c.depth >> 1;
        c.margin = (c.depth == CNT_W'(32)) ? CNT_W'(2) :
                   (c.depth == CNT_W'(64)) ? CNT_W'(3) : CNT_W'(4);
        return c;
    endfunction

endpackage

// File: rtl/jab_store.sv
module jab_store
    import jab_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic [CNT_W-1:0] depth,
    input  logic [CNT_W-1:0] half,
    input  logic             wr_stb,
    input  logic             wr_bit,
    input  logic             rd_tick,
    input  logic             flag_clr,
    output logic             rd_stb,
    output logic             rd_bit,
    output logic [CNT_W-1:0] fill,
    output logic             ovf,
    output logic             unf
);

    logic [MAX_DEPTH-1:0] mem;
    logic [CNT_W-1:0]     wptr, rptr, wnext, rnext, slip_ptr, depth_q;
    logic                 act_q, cfg_chg;

    always_comb begin
        wnext    = (wptr == depth - CNT_W'(1)) ? '0 : wptr + CNT_W'(1);
        rnext    = (rptr == depth - CNT_W'(1)) ? '0 : rptr + CNT_W'(1);
        slip_ptr = (wptr >= half) ? wptr - half : wptr + depth - half;
        cfg_chg  = (depth != depth_q) || (active != act_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mem     <= '0;
            wptr    <= '0;
            rptr    <= half;
            fill    <= half;
            ovf     <= 1'b0;
            unf     <= 1'b0;
            rd_stb  <= 1'b0;
            rd_bit  <= 1'b0;
            depth_q <= depth;
            act_q   <= active;
        end else begin
            depth_q <= depth;
            act_q   <= active;
            rd_stb  <= 1'b0;
            if (flag_clr) begin
                ovf <= 1'b0;
                unf <= 1'b0;
            end
            if (cfg_chg || !active) begin
                wptr <= '0;
                rptr <= half;
                fill <= half;
            end else if (rd_tick && fill == '0) begin
                unf  <= 1'b1;
                rptr <= slip_ptr;
                fill <= half;
            end else if (wr_stb && !rd_tick && fill == depth) begin
                ovf  <= 1'b1;
                rptr <= slip_ptr;
                fill <= half;
            end else begin
                if (wr_stb) begin
                    mem[wptr[PTR_W-1:0]] <= wr_bit;
                    wptr                 <= wnext;
                end
                if (rd_tick) begin
                    rd_bit <= mem[rptr[PTR_W-1:0]];
                    rptr   <= rnext;
                    rd_stb <= 1'b1;
                end
                fill <= fill + CNT_W'(wr_stb) - CNT_W'(rd_tick);
            end
        end
    end

    // R5
    ovf_reload_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf) |-> fill == $past(half));

    // R6
    rd_not_empty_chk: assert property (@(posedge clk) disable iff (rst)
        rd_stb |-> ($past(rd_tick) && $past(fill) != '0));

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf && !flag_clr) |=> ovf);

    // R7
    unf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (unf && !flag_clr) |=> unf);

    // R2
    fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (depth == depth_q) |-> fill <= depth);

endmodule

// File: rtl/jab_nco.sv
module jab_nco
    import jab_pkg::*;
#(
    parameter int ACC_W     = 16,
    parameter int NOM_INC   = 8192,
    parameter int LIM_STEP  = 2048,
    parameter int BROAD_SH  = 3,
    parameter int NARROW_SH = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             broad,
    input  logic             limit_en,
    input  logic [CNT_W-1:0] depth,
    input  logic [CNT_W-1:0] half,
    input  logic [CNT_W-1:0] margin,
    input  logic [CNT_W-1:0] fill,
    output logic             tick
);

    localparam int SW = ACC_W + 2;

    logic [ACC_W-1:0]     acc;
    logic [ACC_W:0]       sum, inc_u;
    logic signed [SW-1:0] err_s, err_g, lim_s, inc_s;
    logic                 near_full, near_empty;

    always_comb begin
        err_s      = $signed({{(SW-CNT_W){1'b0}}, fill}) - $signed({{(SW-CNT_W){1'b0}}, half});
        err_g      = broad ? (err_s <<< BROAD_SH) : (err_s <<< NARROW_SH);
        near_full  = (fill + margin) >= depth;
        near_empty = fill <= margin;
        lim_s      = '0;
        if (limit_en && near_full)
            lim_s = $signed(SW'(LIM_STEP));
        else if (limit_en && near_empty)
            lim_s = -$signed(SW'(LIM_STEP));
        inc_s = $signed(SW'(NOM_INC)) + err_g + lim_s;
        inc_u = (inc_s < $signed(SW'(1))) ? (ACC_W+1)'(1) : inc_s[ACC_W:0];
        sum   = {1'b0, acc} + inc_u;
        tick  = sum[ACC_W];
    end

    always_ff @(posedge clk) begin
        if (rst)
            acc <= '0;
        else
            acc <= sum[ACC_W-1:0];
    end

    // R10
    tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/jitter_buffer.sv
module jitter_buffer
    import jab_pkg::*;
#(
    parameter int ACC_W    = 16,
    parameter int NOM_INC  = 8192,
    parameter int LIM_STEP = 2048
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode,
    input  logic             depth_min,
    input  logic             limit_en,
    input  logic             flag_clr,
    input  logic             in_stb,
    input  logic             in_bit,
    output logic             out_stb,
    output logic             out_bit,
    output logic [CNT_W-1:0] fill_level,
    output logic             tx_side,
    output logic             ovf_flag,
    output logic             unf_flag
);

    ja_cfg_t cfg;
    logic    rd_tick, st_stb, st_bit;

    assign cfg     = ja_decode(mode, depth_min);
    assign tx_side = cfg.tx_side;

    jab_nco #(
        .ACC_W    (ACC_W),
        .NOM_INC  (NOM_INC),
        .LIM_STEP (LIM_STEP),
        .BROAD_SH (3),
        .NARROW_SH(0)
    ) u_nco (
        .clk      (clk),
        .rst      (rst),
        .broad    (cfg.broad),
        .limit_en (limit_en),
        .depth    (cfg.depth),
        .half     (cfg.half),
        .margin   (cfg.margin),
        .fill     (fill_level),
        .tick     (rd_tick)
    );

    jab_store u_store (
        .clk      (clk),
        .rst      (rst),
        .active   (cfg.active),
        .depth    (cfg.depth),
        .half     (cfg.half),
        .wr_stb   (in_stb),
        .wr_bit   (in_bit),
        .rd_tick  (rd_tick),
        .flag_clr (flag_clr),
        .rd_stb   (st_stb),
        .rd_bit   (st_bit),
        .fill     (fill_level),
        .ovf      (ovf_flag),
        .unf      (unf_flag)
    );

    always_comb begin
        if (cfg.active) begin
            out_stb = st_stb;
            out_bit = st_bit;
        end else begin
            out_stb = in_stb;
            out_bit = in_bit;
        end
    end

    // R10
    no_double_stb_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg.active && $past(cfg.active) && out_stb) |=> !out_stb);

endmodule

// File: tb/jitter_buffer_tb.sv
module jitter_buffer_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode = 2'b01;
    logic       depth_min = 1'b0;
    logic       limit_en = 1'b0;
    logic       flag_clr = 1'b0;
    logic       in_stb = 1'b0;
    logic       in_bit = 1'b0;
    logic       out_stb, out_bit, tx_side, ovf_flag, unf_flag;
    logic [7:0] fill_level;

    int n_chk = 0;
    int n_err = 0;
    bit wbits [0:511];

    always #10 clk = ~clk;

    jitter_buffer u_dut (
        .clk(clk), .rst(rst), .mode(mode), .depth_min(depth_min),
        .limit_en(limit_en), .flag_clr(flag_clr), .in_stb(in_stb),
        .in_bit(in_bit), .out_stb(out_stb), .out_bit(out_bit),
        .fill_level(fill_level), .tx_side(tx_side),
        .ovf_flag(ovf_flag), .unf_flag(unf_flag)
    );

    function automatic int exp_depth(input logic [1:0] m, input logic d);
        if (d) return 32;
        return (m == 2'b01) ? 64 : 128;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(input logic [1:0] m, input logic d, input logic lim);
        @(negedge clk);
        rst = 1'b1; mode = m; depth_min = d; limit_en = lim;
        in_stb = 1'b0; flag_clr = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_lat(input logic [1:0] m, input logic d, input int nreads);
        int half, rc, wc, cyc;
        bit prev, expv;
        half = exp_depth(m, d) / 2;
        do_reset(m, d, 1'b0);
        rc = 0; wc = 0; cyc = 0; prev = 1'b0;
        while (rc < nreads && cyc < 20 * nreads) begin
            step();
            cyc++;
            if (out_stb) begin
                expv = (rc < half) ? 1'b0 : wbits[rc - half];
                chk(out_bit == expv, "R3 latency bit", int'(out_bit), int'(expv));
                chk(!prev, "R10 strobe spacing", int'(prev), 0);
                rc++;
                in_stb = 1'b1;
                in_bit = 1'($urandom);
                wbits[wc] = in_bit;
                wc++;
            end else begin
                in_stb = 1'b0;
            end
            prev = out_stb;
        end
        in_stb = 1'b0;
        chk(rc == nreads, "R3 read count", rc, nreads);
        chk(!ovf_flag && !unf_flag, "R3 no slip", int'({ovf_flag, unf_flag}), 0);
    endtask

    task automatic time_drain(input logic lim, output int t);
        do_reset(2'b01, 1'b0, lim);
        t = 0;
        while (!unf_flag && t < 3000) begin step(); t++; end
    endtask

    task automatic time_flood(input logic lim, output int t);
        do_reset(2'b01, 1'b0, lim);
        t = 0;
        while (!ovf_flag && t < 5000) begin
            in_stb = (t % 5 == 4);
            in_bit = 1'($urandom);
            step();
            t++;
        end
        in_stb = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        int n, wc, rc, t_off, t_on;
        n = $urandom(32'd4242);

        // R2 / R4: reset state per configuration
        do_reset(2'b01, 1'b0, 1'b0); step();
        chk(fill_level == 8'd32, "R2 reset fill d64", int'(fill_level), 32);
        chk(!ovf_flag && !unf_flag, "R2 reset flags", int'({ovf_flag, unf_flag}), 0);
        chk(tx_side == 1'b0, "R4 tx_side mode01", int'(tx_side), 0);
        do_reset(2'b10, 1'b0, 1'b0); step();
        chk(fill_level == 8'd64, "R2 reset fill d128", int'(fill_level), 64);
        chk(tx_side == 1'b0, "R4 tx_side mode10", int'(tx_side), 0);
        do_reset(2'b11, 1'b1, 1'b0); step();
        chk(fill_level == 8'd16, "R2 reset fill d32", int'(fill_level), 16);
        chk(tx_side == 1'b1, "R4 tx_side mode11", int'(tx_side), 1);

        // R1: bypass
        do_reset(2'b00, 1'b0, 1'b0);
        for (int i = 0; i < 24; i++) begin
            in_stb = 1'($urandom);
            in_bit = 1'($urandom);
            #1;
            chk(out_stb == in_stb && out_bit == in_bit, "R1 bypass",
                int'({out_stb, out_bit}), int'({in_stb, in_bit}));
            step();
        end
        in_stb = 1'b0;

        // R8: read instants from reset, broad and narrow
        for (int k = 0; k < 2; k++) begin
            do_reset(k == 0 ? 2'b01 : 2'b10, 1'b0, 1'b0);
            n = 0;
            do begin step(); n++; end while (!out_stb && n < 50);
            chk(n == 8, "R8 first read edge", n, 8);
            n = 0;
            do begin step(); n++; end while (!out_stb && n < 50);
            chk(n == 9, "R8 second read interval", n, 9);
        end

        // R3 / R10: half-depth latency under random data
        run_lat(2'b01, 1'b0, 100);
        run_lat(2'b10, 1'b0, 170);
        run_lat(2'b11, 1'b0, 150);
        run_lat(2'b01, 1'b1, 60);

        // R5: overflow under continuous writes
        do_reset(2'b01, 1'b0, 1'b0);
        wc = 0; rc = 0; in_stb = 1'b1;
        for (int i = 0; i < 400; i++) begin
            in_bit = 1'($urandom);
            @(posedge clk); wc++;
            @(negedge clk);
            if (out_stb) rc++;
            if (ovf_flag) break;
        end
        in_stb = 1'b0;
        chk(ovf_flag == 1'b1, "R5 overflow set", int'(ovf_flag), 1);
        chk(wc - rc == 33, "R5 overflow position", wc - rc, 33);
        chk(fill_level == 8'd32, "R5 reload fill", int'(fill_level), 32);
        repeat (20) step();
        chk(ovf_flag == 1'b1, "R7 overflow sticky", int'(ovf_flag), 1);
        flag_clr = 1'b1; step(); flag_clr = 1'b0;
        chk(ovf_flag == 1'b0, "R7 overflow cleared", int'(ovf_flag), 0);

        // R6: underflow with no writes, depth 32
        do_reset(2'b10, 1'b1, 1'b0);
        rc = 0;
        for (int i = 0; i < 2000; i++) begin
            step();
            if (unf_flag) break;
            if (out_stb) rc++;
        end
        chk(unf_flag == 1'b1, "R6 underflow set", int'(unf_flag), 1);
        chk(rc == 16, "R6 reads before underflow", rc, 16);
        chk(out_stb == 1'b0, "R6 no strobe on empty read", int'(out_stb), 0);
        chk(fill_level == 8'd16, "R6 reload fill", int'(fill_level), 16);
        flag_clr = 1'b1; step(); flag_clr = 1'b0;
        chk(unf_flag == 1'b0, "R7 underflow cleared", int'(unf_flag), 0);

        // R9: limit mode delays both edges
        time_drain(1'b0, t_off);
        time_drain(1'b1, t_on);
        chk(t_on > t_off, "R9 drain slower with limit", t_on, t_off + 1);
        time_flood(1'b0, t_off);
        time_flood(1'b1, t_on);
        chk(t_on > t_off, "R9 flood later with limit", t_on, t_off + 1);

        // R11: configuration change re-centres
        do_reset(2'b01, 1'b0, 1'b0);
        repeat (20) step();
        mode = 2'b10; step();
        chk(fill_level == 8'd64, "R11 recentre to 128", int'(fill_level), 64);
        depth_min = 1'b1; step();
        chk(fill_level == 8'd16, "R11 recentre to 32", int'(fill_level), 16);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule